// File: doc/BRIEF.md
# Fetch Group Builder with Next-PC Prediction

This block sits between the instruction cache and decode for a single thread. Each cycle it is offered one cache line together with that line's block address. If the line covers the thread's current fetch address, the block cuts a group of consecutive 32-bit instructions out of the line. The group starts at the current PC and holds at most `FW` slots. For every slot the block reports the instruction, its PC, the predicted next PC and next-next PC, whether it is a control instruction and whether it was predicted taken. Each slot also carries a sequence number. The block then advances its PC pair so that the next cycle resumes where the group ended.

An external branch predictor answers one question per slot: for slot i it supplies a taken bit and a target address. The block only uses that answer when the slot holds a control instruction. A build-time parameter selects between two next-PC rules: plain sequential semantics, or a single branch delay slot.

A redirect input loads a new PC pair and clears the stopped states. A quiesce instruction stops fetch until the next redirect. A translation fault produces a single no-op slot marked as faulting and leaves the thread waiting for a trap until the next redirect. Three running counters record fetched instructions, control instructions and predicted-taken control instructions.

Top module: `fetch_group`

## Requirements
- R1: After reset, cur_pc is RESET_PC and cur_npc is RESET_PC+4. The block is neither halted nor trap-pending, all counters and the sequence counter are zero, and no slot is valid.
- R2: When redir_valid is high, no slot is valid in that cycle. On the next cycle cur_pc and cur_npc equal redir_pc and redir_npc, and halted and trap_pending are both low.
- R3: A group is built only when line_valid is high, the block is running, no redirect is present, and line_addr equals cur_pc outside the line-offset bits. Otherwise no slot is valid and cur_pc/cur_npc hold.
- R4: The first slot reads the line at cur_pc's line offset with its two low bits cleared. Each later slot reads the next 32-bit word. The group never extends past the end of the line.
- R5: At most FW slots are valid, the valid slots form a prefix starting at slot 0, and grp_count equals their number.
- R6: The group ends after any instruction whose PC+4 differs from its own next PC.
- R7: Instructions whose top nibble is 0xC are control instructions; all others are not. For a non-control instruction the predicted next PC is its next PC and the next-next PC is that value plus 4. Such a slot is never marked taken, whatever bp_taken says.
- R8: With DELAY_SLOT=0, a control instruction predicts its target when taken and PC+4 when not taken. Its next-next PC is the predicted next PC plus 4.
- R9: With DELAY_SLOT=1, a control instruction predicts its own next PC. Its next-next PC is the target when taken, or its next PC plus 4 when not taken.
- R10: A control instruction predicted taken is the last slot of its group.
- R11: An instruction whose top nibble is 0xF (quiesce) is emitted and counted. It ends the group, and halted then stays high with no slots until a redirect.
- R12: With xlat_fault high on a cycle that would build a group, exactly one slot is emitted. That slot holds the all-zero word with slot_fault set. trap_pending then stays high with no slots until a redirect, and cur_pc/cur_npc are unchanged.
- R13: Slot i carries the sequence counter value plus i. The counter starts at 0 and advances by grp_count each cycle.
- R14: cnt_insts, cnt_ctrl and cnt_taken advance each cycle by the number of valid slots, valid control slots and valid taken slots respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| redir_valid | input | 1 | Load a new PC pair and resume |
| redir_pc | input | AW | PC to load |
| redir_npc | input | AW | Next PC to load |
| line_valid | input | 1 | A cache line is offered this cycle |
| line_addr | input | AW | Address of the offered line |
| line_data | input | 8*LINE_BYTES | Line contents, byte 0 in the low bits |
| xlat_fault | input | 1 | Address translation failed for this fetch |
| bp_taken | input | FW | Predictor taken bit per slot |
| bp_target | input | FW*AW | Predictor target per slot |
| slot_valid | output | FW | Slot holds an instruction |
| slot_inst | output | FW*32 | Instruction word per slot |
| slot_pc | output | FW*AW | PC per slot |
| slot_pnpc | output | FW*AW | Predicted next PC per slot |
| slot_pnnpc | output | FW*AW | Predicted next-next PC per slot |
| slot_ctrl | output | FW | Slot is a control instruction |
| slot_taken | output | FW | Slot is predicted taken |
| slot_fault | output | FW | Slot is a translation-fault no-op |
| slot_seq | output | FW*SW | Sequence number per slot |
| grp_count | output | clog2(FW+1) | Number of valid slots |
| cur_pc | output | AW | Current fetch PC |
| cur_npc | output | AW | Current next PC |
| halted | output | 1 | Stopped by a quiesce instruction |
| trap_pending | output | 1 | Stopped by a translation fault |
| cnt_insts | output | CW | Fetched instruction count |
| cnt_ctrl | output | CW | Fetched control instruction count |
| cnt_taken | output | CW | Predicted-taken control count |

## Verification
The properties assume the predictor answers combinationally in the same cycle as the slot PCs it sees. They also assume redirect addresses are 4-byte aligned and that line_data is stable while line_valid is high. The stimulus always redirects to word-aligned PCs inside one fixed line. It drives all predictor taken bits together, so the control slot that matters sees the required answer and non-control slots see a taken bit that must be ignored. Next-PC values are either sequential or a jump well outside the line, so a discontinuity is never hidden by a target that lands back on PC+4.

// File: rtl/fetch_group.sv
module fetch_group #(
  parameter int unsigned AW         = 32,
  parameter int unsigned LINE_BYTES = 32,
  parameter int unsigned FW         = 4,
  parameter int unsigned SW         = 16,
  parameter int unsigned CW         = 16,
  parameter bit          DELAY_SLOT = 1'b0,
  parameter logic [31:0] RESET_PC   = 32'h0,
  parameter logic [31:0] NOP_INST   = 32'h0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    redir_valid,
  input  logic [AW-1:0]           redir_pc,
  input  logic [AW-1:0]           redir_npc,
  input  logic                    line_valid,
  input  logic [AW-1:0]           line_addr,
  input  logic [8*LINE_BYTES-1:0] line_data,
  input  logic                    xlat_fault,
  input  logic [FW-1:0]           bp_taken,
  input  logic [FW*AW-1:0]        bp_target,
  output logic [FW-1:0]           slot_valid,
  output logic [FW*32-1:0]        slot_inst,
  output logic [FW*AW-1:0]        slot_pc,
  output logic [FW*AW-1:0]        slot_pnpc,
  output logic [FW*AW-1:0]        slot_pnnpc,
  output logic [FW-1:0]           slot_ctrl,
  output logic [FW-1:0]           slot_taken,
  output logic [FW-1:0]           slot_fault,
  output logic [FW*SW-1:0]        slot_seq,
  output logic [$clog2(FW+1)-1:0] grp_count,
  output logic [AW-1:0]           cur_pc,
  output logic [AW-1:0]           cur_npc,
  output logic                    halted,
  output logic                    trap_pending,
  output logic [CW-1:0]           cnt_insts,
  output logic [CW-1:0]           cnt_ctrl,
  output logic [CW-1:0]           cnt_taken
);
  localparam int unsigned ISZ  = 4;
  localparam int unsigned ISH  = 2;
  localparam int unsigned OFFW = $clog2(LINE_BYTES);
  localparam int unsigned CNTW = $clog2(FW+1);

  typedef enum logic [1:0] {ST_RUN, ST_HALT, ST_TRAP} state_t;

  state_t          st_q;
  logic [AW-1:0]   pc_q, npc_q;
  logic [SW-1:0]   seq_q;
  logic [OFFW-1:0] base_off;
  logic            go, fault_go;
  logic [FW:0][AW-1:0] pch, nch;
  logic [FW:0]     alive;
  logic [FW-1:0]   v, qui;
  logic [CNTW-1:0] n_v, n_c, n_t;

  assign go       = line_valid && st_q == ST_RUN && !redir_valid &&
                    line_addr[AW-1:OFFW] == pc_q[AW-1:OFFW];
  assign fault_go = go && xlat_fault;
  assign base_off = {pc_q[OFFW-1:ISH], {ISH{1'b0}}};
  assign pch[0]   = pc_q;
  assign nch[0]   = npc_q;
  assign alive[0] = go && !xlat_fault;

  for (genvar i = 0; i < FW; i++) begin : g_slot
    logic [31:0]     off;
    logic [OFFW+2:0] bitpos;
    logic [31:0]     inst;
    logic            in_line, ctrl, tk, brk;
    logic [AW-1:0]   tgt, np, nn, seqpc;

    assign off     = 32'(base_off) + 32'(i*ISZ);
    assign in_line = off < 32'(LINE_BYTES);
    assign bitpos  = {off[OFFW-1:0], 3'b000};
    assign inst    = line_data[bitpos +: 32];
    assign v[i]    = alive[i] && in_line;
    assign ctrl    = inst[31:28] == 4'hC;
    assign qui[i]  = inst[31:28] == 4'hF;
    assign tk      = ctrl && bp_taken[i];
    assign tgt     = bp_target[i*AW +: AW];
    assign seqpc   = pch[i] + AW'(ISZ);

    if (DELAY_SLOT) begin : g_ds
      assign np = nch[i];
      assign nn = tk ? tgt : nch[i] + AW'(ISZ);
    end else begin : g_nds
      assign np = !ctrl ? nch[i] : (tk ? tgt : seqpc);
      assign nn = np + AW'(ISZ);
    end

    assign brk        = seqpc != nch[i] || tk || qui[i];
    assign alive[i+1] = v[i] && !brk;
    assign pch[i+1]   = v[i] ? np : pch[i];
    assign nch[i+1]   = v[i] ? nn : nch[i];

    assign slot_valid[i]          = v[i] || (i == 0 && fault_go);
    assign slot_fault[i]          = i == 0 && fault_go;
    assign slot_inst[i*32 +: 32]  = fault_go ? NOP_INST : inst;
    assign slot_pc[i*AW +: AW]    = pch[i];
    assign slot_pnpc[i*AW +: AW]  = np;
    assign slot_pnnpc[i*AW +: AW] = nn;
    assign slot_ctrl[i]           = v[i] && ctrl;
    assign slot_taken[i]          = v[i] && tk;
    assign slot_seq[i*SW +: SW]   = seq_q + SW'(i);
  end

  always_comb begin
    n_v = '0; n_c = '0; n_t = '0;
    for (int i = 0; i < FW; i++) begin
      n_v = n_v + CNTW'(slot_valid[i]);
      n_c = n_c + CNTW'(slot_ctrl[i]);
      n_t = n_t + CNTW'(slot_taken[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_RUN;
      pc_q      <= AW'(RESET_PC);
      npc_q     <= AW'(RESET_PC) + AW'(ISZ);
      seq_q     <= '0;
      cnt_insts <= '0;
      cnt_ctrl  <= '0;
      cnt_taken <= '0;
    end else begin
      if (redir_valid) begin
        st_q  <= ST_RUN;
        pc_q  <= redir_pc;
        npc_q <= redir_npc;
      end else if (fault_go) begin
        st_q <= ST_TRAP;
      end else if (go) begin
        pc_q  <= pch[FW];
        npc_q <= nch[FW];
        if (|(v & qui)) st_q <= ST_HALT;
      end
      seq_q     <= seq_q + SW'(n_v);
      cnt_insts <= cnt_insts + CW'(n_v);
      cnt_ctrl  <= cnt_ctrl + CW'(n_c);
      cnt_taken <= cnt_taken + CW'(n_t);
    end
  end

  assign grp_count    = n_v;
  assign cur_pc       = pc_q;
  assign cur_npc      = npc_q;
  assign halted       = st_q == ST_HALT;
  assign trap_pending = st_q == ST_TRAP;
endmodule

// File: rtl/fetch_group_chk.sv
module fetch_group_chk #(
  parameter int unsigned AW = 32,
  parameter int unsigned FW = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    redir_valid,
  input logic [AW-1:0]           redir_pc,
  input logic [AW-1:0]           redir_npc,
  input logic [FW-1:0]           slot_valid,
  input logic [FW-1:0]           slot_taken,
  input logic [FW-1:0]           slot_fault,
  input logic [$clog2(FW+1)-1:0] grp_count,
  input logic [AW-1:0]           cur_pc,
  input logic [AW-1:0]           cur_npc,
  input logic                    halted,
  input logic                    trap_pending
);
  p_prefix_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(FW'(slot_valid + 1'b1)));

  p_redirect_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> cur_pc == $past(redir_pc) && cur_npc == $past(redir_npc)
                    && !halted && !trap_pending);

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !redir_valid && slot_valid == '0 |=> $stable(cur_pc) && $stable(cur_npc));

  p_taken_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_taken & (slot_valid >> 1)) == '0);

  p_halt_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> slot_valid == '0);

  p_trap_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    trap_pending |-> slot_valid == '0);

  p_fault_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    |slot_fault |-> grp_count == 1 && slot_fault[0]);
endmodule

bind fetch_group fetch_group_chk #(.AW(AW), .FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .redir_valid(redir_valid), .redir_pc(redir_pc),
  .redir_npc(redir_npc), .slot_valid(slot_valid), .slot_taken(slot_taken),
  .slot_fault(slot_fault), .grp_count(grp_count), .cur_pc(cur_pc),
  .cur_npc(cur_npc), .halted(halted), .trap_pending(trap_pending));

// File: tb/test_fetch_group.sv
module test_fetch_group;
  localparam int CLK_PERIOD = 10;
  localparam int FW = 4;
  localparam int AW = 32;
  localparam int LB = 32;
  localparam int SW = 16;
  localparam int CW = 16;
  localparam logic [31:0] LBASE = 32'h1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic redir_valid = 0, line_valid = 0, xlat_fault = 0;
  logic [31:0] redir_pc = 0, redir_npc = 0, line_addr = 0;
  logic [255:0] line_data = 0;
  logic [FW-1:0] bp_taken = 0;
  logic [FW*AW-1:0] bp_target = 0;

  logic [FW-1:0] sv_a, sc_a, st_a, sf_a, sv_b, sc_b, st_b, sf_b;
  logic [FW*32-1:0] si_a, si_b;
  logic [FW*AW-1:0] sp_a, snp_a, snn_a, sp_b, snp_b, snn_b;
  logic [FW*SW-1:0] sq_a, sq_b;
  logic [2:0] gc_a, gc_b;
  logic [31:0] pc_a, npc_a, pc_b, npc_b;
  logic h_a, t_a, h_b, t_b;
  logic [CW-1:0] ci_a, cc_a, ct_a, ci_b, cc_b, ct_b;

  fetch_group #(.DELAY_SLOT(1'b0)) i_fetch_group (
    .clk, .rst_n, .redir_valid, .redir_pc, .redir_npc, .line_valid, .line_addr,
    .line_data, .xlat_fault, .bp_taken, .bp_target,
    .slot_valid(sv_a), .slot_inst(si_a), .slot_pc(sp_a), .slot_pnpc(snp_a),
    .slot_pnnpc(snn_a), .slot_ctrl(sc_a), .slot_taken(st_a), .slot_fault(sf_a),
    .slot_seq(sq_a), .grp_count(gc_a), .cur_pc(pc_a), .cur_npc(npc_a),
    .halted(h_a), .trap_pending(t_a), .cnt_insts(ci_a), .cnt_ctrl(cc_a),
    .cnt_taken(ct_a));

  fetch_group #(.DELAY_SLOT(1'b1)) i_fetch_group_ds (
    .clk, .rst_n, .redir_valid, .redir_pc, .redir_npc, .line_valid, .line_addr,
    .line_data, .xlat_fault, .bp_taken, .bp_target,
    .slot_valid(sv_b), .slot_inst(si_b), .slot_pc(sp_b), .slot_pnpc(snp_b),
    .slot_pnnpc(snn_b), .slot_ctrl(sc_b), .slot_taken(st_b), .slot_fault(sf_b),
    .slot_seq(sq_b), .grp_count(gc_b), .cur_pc(pc_b), .cur_npc(npc_b),
    .halted(h_b), .trap_pending(t_b), .cnt_insts(ci_b), .cnt_ctrl(cc_b),
    .cnt_taken(ct_b));

  int checks = 0, fails = 0;
  int e_cnt;
  logic [31:0] e_pc[FW], e_np[FW], e_nn[FW], e_inst[FW];
  bit e_ctrl[FW], e_tk[FW];
  logic [31:0] e_fpc, e_fnpc;
  bit e_q;
  logic [7:0] cmask, qmask;
  int t_i[2], t_c[2], t_t[2];
  logic [15:0] e_seq[2];

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] word_at(input int w);
    if (cmask[w]) return 32'hC000_0000 | 32'(w);
    if (qmask[w]) return 32'hF000_0000 | 32'(w);
    return 32'h1000_0000 | 32'(w);
  endfunction

  task automatic build_line();
    for (int w = 0; w < 8; w++) line_data[w*32 +: 32] = word_at(w);
  endtask

  task automatic model(input int d, input logic [31:0] pc, input logic [31:0] npc,
                       input logic [FW-1:0] tks, input logic [31:0] tgt);
    logic [31:0] p, n, np, nn;
    bit ctrl, tk, q;
    int w;
    p = pc; n = npc; e_cnt = 0; e_q = 0;
    for (int i = 0; i < FW; i++) begin
      w = int'(pc[4:2]) + i;
      if (w > 7) break;
      ctrl = cmask[w]; q = qmask[w]; tk = ctrl && tks[i];
      if (!ctrl) begin np = n; nn = n + 4; end
      else if (d == 0) begin np = tk ? tgt : p + 4; nn = np + 4; end
      else begin np = n; nn = tk ? tgt : n + 4; end
      e_pc[i] = p; e_np[i] = np; e_nn[i] = nn; e_inst[i] = word_at(w);
      e_ctrl[i] = ctrl; e_tk[i] = tk; e_cnt++;
      if (q) e_q = 1;
      p = np; n = nn;
      if ((e_pc[i] + 4 != e_np[i] && !ctrl) || e_pc[i] + 4 != ((i == 0) ? npc : e_nn[i-1]) || tk || q) break;
    end
    e_fpc = p; e_fnpc = n;
  endtask

  task automatic check_slots(input int d);
    logic [FW-1:0] sv, sc, stk;
    logic [FW*32-1:0] si;
    logic [FW*AW-1:0] sp, snp, snn;
    logic [FW*SW-1:0] sq;
    logic [2:0] gc;
    string rq;
    sv = d ? sv_b : sv_a; sc = d ? sc_b : sc_a; stk = d ? st_b : st_a;
    si = d ? si_b : si_a; sp = d ? sp_b : sp_a; snp = d ? snp_b : snp_a;
    snn = d ? snn_b : snn_a; sq = d ? sq_b : sq_a; gc = d ? gc_b : gc_a;
    chk(gc == 3'(e_cnt), "R4/R5/R6/R10 group size", 64'(gc), 64'(e_cnt));
    for (int i = 0; i < FW; i++) begin
      if (i < e_cnt) begin
        rq = e_ctrl[i] ? (d ? "R9" : "R8") : "R7";
        chk(sv[i] && sp[i*32 +: 32] == e_pc[i] && si[i*32 +: 32] == e_inst[i],
            "R4 slot pc/inst", {sp[i*32 +: 32], si[i*32 +: 32]}, {e_pc[i], e_inst[i]});
        chk(snp[i*32 +: 32] == e_np[i] && snn[i*32 +: 32] == e_nn[i], rq,
            {snp[i*32 +: 32], snn[i*32 +: 32]}, {e_np[i], e_nn[i]});
        chk(sc[i] == e_ctrl[i] && stk[i] == e_tk[i], "R7 ctrl/taken flags",
            {62'd0, sc[i], stk[i]}, {62'd0, e_ctrl[i], e_tk[i]});
        chk(sq[i*16 +: 16] == e_seq[d] + 16'(i), "R13 sequence",
            64'(sq[i*16 +: 16]), 64'(e_seq[d] + 16'(i)));
      end else begin
        chk(!sv[i], "R5 slot beyond group", 64'(sv[i]), 64'd0);
      end
    end
  endtask

  task automatic tally(input int d);
    t_i[d] += e_cnt;
    for (int i = 0; i < e_cnt; i++) begin
      t_c[d] += int'(e_ctrl[i]);
      t_t[d] += int'(e_tk[i]);
    end
    e_seq[d] += 16'(e_cnt);
  endtask

  task automatic redirect(input logic [31:0] pc, input logic [31:0] npc);
    @(negedge clk);
    redir_valid = 1; redir_pc = pc; redir_npc = npc; line_valid = 0; xlat_fault = 0;
    @(negedge clk);
    redir_valid = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int d = 0; d < 2; d++) begin t_i[d] = 0; t_c[d] = 0; t_t[d] = 0; e_seq[d] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk(pc_a == 0 && npc_a == 4 && pc_b == 0 && npc_b == 4, "R1 reset pc", {pc_a, npc_a}, 64'h4);
    chk(!h_a && !t_a && !h_b && !t_b && sv_a == 0 && sv_b == 0 && ci_a == 0 && cc_b == 0,
        "R1 reset state", 64'({h_a, t_a, h_b, t_b, sv_a, sv_b}), 64'd0);

    // Main sweep over start word, npc continuity, control position, taken
    for (int s = 0; s < 8; s++)
      for (int disc = 0; disc < 2; disc++)
        for (int c = 0; c < 9; c++)
          for (int tk = 0; tk < 2; tk++) begin
            logic [31:0] pc, npc, tgt;
            pc = LBASE + 32'(4*s);
            npc = disc ? pc + 32'h40 : pc + 4;
            tgt = 32'h2000 + 32'(16*s);
            cmask = (c < 8) ? 8'(1 << c) : 8'h00;
            qmask = 8'h00;
            redirect(pc, npc);
            line_valid = 1; line_addr = LBASE; build_line();
            bp_taken = tk ? 4'hF : 4'h0;
            bp_target = {FW{tgt}};
            #1;
            for (int d = 0; d < 2; d++) begin
              model(d, pc, npc, bp_taken, tgt);
              check_slots(d);
            end
            @(negedge clk);
            line_valid = 0;
            #1;
            for (int d = 0; d < 2; d++) begin
              model(d, pc, npc, bp_taken, tgt);
              chk((d ? pc_b : pc_a) == e_fpc && (d ? npc_b : npc_a) == e_fnpc,
                  d ? "R9 pc pair update" : "R8 pc pair update",
                  {(d ? pc_b : pc_a), (d ? npc_b : npc_a)}, {e_fpc, e_fnpc});
              tally(d);
            end
          end

    // Line address mismatch: nothing fetched, pc holds
    redirect(LBASE, LBASE + 4);
    #1;
    chk(pc_a == LBASE && npc_a == LBASE + 4, "R2 redirect load", {pc_a, npc_a}, {LBASE, LBASE + 32'd4});
    line_valid = 1; line_addr = 32'h3000; cmask = 0; qmask = 0; build_line(); bp_taken = 0;
    #1;
    chk(sv_a == 0 && sv_b == 0, "R3 line mismatch no slots", 64'({sv_a, sv_b}), 64'd0);
    @(negedge clk); line_valid = 0; #1;
    chk(pc_a == LBASE && pc_b == LBASE, "R3 pc hold on mismatch", {pc_a, pc_b}, {LBASE, LBASE});

    // Quiesce at word 2
    redirect(LBASE, LBASE + 4);
    line_valid = 1; line_addr = LBASE; cmask = 0; qmask = 8'h04; build_line();
    #1;
    for (int d = 0; d < 2; d++) begin model(d, LBASE, LBASE + 4, 4'h0, 32'h0); check_slots(d); tally(d); end
    chk(gc_a == 3, "R11 quiesce emitted", 64'(gc_a), 64'd3);
    @(negedge clk); #1;
    chk(h_a && h_b, "R11 halted after quiesce", 64'({h_a, h_b}), 64'h3);
    chk(sv_a == 0 && sv_b == 0, "R11 no fetch while halted", 64'({sv_a, sv_b}), 64'd0);
    line_valid = 0;
    redirect(LBASE, LBASE + 4);
    #1;
    chk(!h_a && !h_b, "R2 redirect clears halt", 64'({h_a, h_b}), 64'd0);

    // Translation fault
    redirect(LBASE + 8, LBASE + 12);
    line_valid = 1; line_addr = LBASE; qmask = 0; build_line(); xlat_fault = 1;
    #1;
    chk(gc_a == 1 && sv_a == 4'b0001 && sf_a == 4'b0001 && si_a[31:0] == 32'h0,
        "R12 fault slot", {gc_a, sv_a, sf_a, si_a[31:0]}, 64'h1_1_1_00000000);
    chk(gc_b == 1 && sf_b == 4'b0001 && sq_b[15:0] == e_seq[1], "R12 fault slot ds",
        {gc_b, sq_b[15:0]}, {3'd1, e_seq[1]});
    for (int d = 0; d < 2; d++) begin t_i[d] += 1; e_seq[d] += 1; end
    @(negedge clk); xlat_fault = 0; #1;
    chk(t_a && t_b && pc_a == LBASE + 8 && npc_a == LBASE + 12, "R12 trap pending, pc held",
        {31'd0, t_a, pc_a}, {31'd0, 1'b1, LBASE + 32'd8});
    chk(sv_a == 0 && sv_b == 0, "R12 no fetch while trap pending", 64'({sv_a, sv_b}), 64'd0);
    line_valid = 0;
    redirect(LBASE, LBASE + 4);
    #1;
    chk(!t_a && !t_b, "R2 redirect clears trap", 64'({t_a, t_b}), 64'd0);

    // Counters
    chk(ci_a == 16'(t_i[0]) && cc_a == 16'(t_c[0]) && ct_a == 16'(t_t[0]), "R14 counters",
        {ci_a, cc_a, ct_a}, {16'(t_i[0]), 16'(t_c[0]), 16'(t_t[0])});
    chk(ci_b == 16'(t_i[1]) && cc_b == 16'(t_c[1]) && ct_b == 16'(t_t[1]), "R14 counters ds",
        {ci_b, cc_b, ct_b}, {16'(t_i[1]), 16'(t_c[1]), 16'(t_t[1])});
    chk(sq_a[15:0] == e_seq[0] && sq_b[15:0] == e_seq[1], "R13 sequence total",
        {sq_a[15:0], sq_b[15:0]}, {e_seq[0], e_seq[1]});

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule